// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block turns three active-low asynchronous reset requests into the reset domains used inside a chip. The requests are a power-on reset, a power-fail warning and a user reset button. The block derives four domain resets from them. The system reset clears nearly all state. The power-on reset clears only the state that must survive the other two requests. The standby reset follows the run input. The processor reset holds the core until the chip is back in the operating state. Every domain reset asserts at once, without waiting for a clock edge, and releases in step with the system clock through a synchroniser chain.

A small register file sits beside the reset logic to show which domain clears which state. It holds a general control word and a frame-buffer base address that resets to `0xC000_0000`. Both belong to the system domain. It also holds a memory refresh period and a pair of real-time-clock words, data and match, which belong to the power-on domain. A plain write port (address, data, enable) loads the registers, and a combinational read port returns them.

Top module: `sysreset_hub`

## Requirements
- R1: While any of `por_n`, `pwrfail_n` or `usr_rst_n` is low, `sys_rst_n` is low with no clock edge needed.
- R2: Once the last of the three inputs goes high, `sys_rst_n` rises on the second rising clock edge after that.
- R3: `por_rst_n` is driven low only by `por_n`. It asserts at once and rises on the second clock edge after `por_n` goes high. Low pulses on `pwrfail_n` or `usr_rst_n` leave it high.
- R4: The refresh-period register (address 1), the RTC data register (address 2) and the RTC match register (address 3) are cleared to zero only by the power-on reset. A system reset caused by power-fail or user reset leaves them unchanged.
- R5: The system reset clears the control register (address 0) to zero and sets the frame-buffer base register (address 4) to `0xC000_0000`.
- R6: `stby_rst_n` is low while `run` is low or `por_n` is low. It rises on the second clock edge after both are high. It never affects register contents.
- R7: `cpu_rst_n` is low whenever `sys_rst_n` or `stby_rst_n` is low. It rises on the first clock edge at which both are already high, which is the third edge after the inputs release.
- R8: With `wr_en` high and `sys_rst_n` high, a rising edge loads `wr_data` into the register at `wr_addr`. `rd_data` shows the register at `rd_addr` with no delay. Addresses 5 to 7 read as zero, and writes to them change no register.
- R9: A write presented while `sys_rst_n` is low, including the cycles while its synchroniser is still releasing, is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset request, active low, asynchronous |
| pwrfail_n | input | 1 | Power-fail reset request, active low, asynchronous |
| usr_rst_n | input | 1 | User reset request, active low, asynchronous |
| run | input | 1 | High when the chip is in the operating state |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data |
| sys_rst_n | output | 1 | System-domain reset, active low |
| por_rst_n | output | 1 | Power-on-domain reset, active low |
| stby_rst_n | output | 1 | Standby-domain reset, active low |
| cpu_rst_n | output | 1 | Processor reset, active low |

## Verification
Two functions can fall in the same cycle: a register write, and the assertion or release of the system reset. The bench drives a write strobe in the same cycle that it pulls a reset input low. It also issues writes in the cycle after a reset input returns high, while the synchroniser has not yet released the system domain. Each write is judged by reading the target register afterwards: the register must hold its reset value, or for the power-on domain its earlier contents, and never the written word. A sweep over all seven combinations of the three reset inputs checks, for each register, what survives, with the expected values computed from which inputs took part.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam logic [DATA_W-1:0] FB_RESET = 32'hC000_0000;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_REFR   = 3'd1,
    A_RTCDAT = 3'd2,
    A_RTCMAT = 3'd3,
    A_FBBASE = 3'd4
  } reg_addr_e;

  // Write enable for one register: strobe, domain open, address match.
  function automatic logic wr_hit(input logic en, input logic open_n,
                                  input logic [ADDR_W-1:0] addr,
                                  input reg_addr_e target);
    return en && open_n && (addr == target);
  endfunction
endpackage

// File: rtl/sysrst_sync.sv
module sysrst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n)
        if (!arst_n) chain_q <= '0;
        else         chain_q <= 1'b1;
    end else begin : g_many
      always_ff @(posedge clk or negedge arst_n)
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/sysrst_regs.sv
module sysrst_regs
  import sysrst_pkg::*;
(
  input  logic              clk,
  input  logic              sys_rst_n,
  input  logic              por_rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] refr_q,
  output logic [DATA_W-1:0] rtcdat_q,
  output logic [DATA_W-1:0] rtcmat_q,
  output logic [DATA_W-1:0] fbbase_q
);
  // System domain
  always_ff @(posedge clk or negedge sys_rst_n)
    if (!sys_rst_n) begin
      ctrl_q   <= '0;
      fbbase_q <= FB_RESET;
    end else begin
      if (wr_hit(wr_en, sys_rst_n, wr_addr, A_CTRL))   ctrl_q   <= wr_data;
      if (wr_hit(wr_en, sys_rst_n, wr_addr, A_FBBASE)) fbbase_q <= wr_data;
    end

  // Power-on domain; writes still need the system domain open
  always_ff @(posedge clk or negedge por_rst_n)
    if (!por_rst_n) begin
      refr_q   <= '0;
      rtcdat_q <= '0;
      rtcmat_q <= '0;
    end else begin
      if (wr_hit(wr_en, sys_rst_n, wr_addr, A_REFR))   refr_q   <= wr_data;
      if (wr_hit(wr_en, sys_rst_n, wr_addr, A_RTCDAT)) rtcdat_q <= wr_data;
      if (wr_hit(wr_en, sys_rst_n, wr_addr, A_RTCMAT)) rtcmat_q <= wr_data;
    end

  always_comb begin
    case (rd_addr)
      A_CTRL:   rd_data = ctrl_q;
      A_REFR:   rd_data = refr_q;
      A_RTCDAT: rd_data = rtcdat_q;
      A_RTCMAT: rd_data = rtcmat_q;
      A_FBBASE: rd_data = fbbase_q;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/sysreset_hub.sv
module sysreset_hub
  import sysrst_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              pwrfail_n,
  input  logic              usr_rst_n,
  input  logic              run,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              sys_rst_n,
  output logic              por_rst_n,
  output logic              stby_rst_n,
  output logic              cpu_rst_n
);
  logic sys_raw_n;
  logic stby_raw_n;
  logic cpu_gate_n;
  logic cpu_q;
  logic [DATA_W-1:0] ctrl_q, refr_q, rtcdat_q, rtcmat_q, fbbase_q;

  assign sys_raw_n  = por_n & pwrfail_n & usr_rst_n;
  assign stby_raw_n = por_n & run;

  sysrst_sync #(.STAGES(SYNC_STAGES)) u_sync_sys (
    .clk(clk), .arst_n(sys_raw_n), .srst_n(sys_rst_n));
  sysrst_sync #(.STAGES(SYNC_STAGES)) u_sync_por (
    .clk(clk), .arst_n(por_n), .srst_n(por_rst_n));
  sysrst_sync #(.STAGES(SYNC_STAGES)) u_sync_stby (
    .clk(clk), .arst_n(stby_raw_n), .srst_n(stby_rst_n));

  // Processor held until both synchronised domains are open
  assign cpu_gate_n = sys_rst_n & stby_rst_n;
  always_ff @(posedge clk or negedge cpu_gate_n)
    if (!cpu_gate_n) cpu_q <= 1'b0;
    else             cpu_q <= 1'b1;
  assign cpu_rst_n = cpu_q;

  sysrst_regs u_regs (
    .clk(clk), .sys_rst_n(sys_rst_n), .por_rst_n(por_rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .ctrl_q(ctrl_q), .refr_q(refr_q), .rtcdat_q(rtcdat_q),
    .rtcmat_q(rtcmat_q), .fbbase_q(fbbase_q));
endmodule

// File: rtl/sysrst_chk.sv
module sysrst_chk
  import sysrst_pkg::*;
(
  input logic              clk,
  input logic              por_n,
  input logic              pwrfail_n,
  input logic              usr_rst_n,
  input logic              run,
  input logic              sys_raw_n,
  input logic              sys_rst_n,
  input logic              por_rst_n,
  input logic              stby_rst_n,
  input logic              cpu_rst_n,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [DATA_W-1:0] refr_q,
  input logic [DATA_W-1:0] rtcdat_q,
  input logic [DATA_W-1:0] rtcmat_q,
  input logic [DATA_W-1:0] fbbase_q
);
  assert_any_src_R1: assert property (@(posedge clk) disable iff (!por_n)
    (!pwrfail_n || !usr_rst_n) |-> !sys_rst_n);

  assert_sync_release_R2: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sys_rst_n) |-> $past(sys_raw_n));

  assert_por_only_R3: assert property (@(posedge clk) disable iff (!por_n)
    $past(por_n) |-> !$fell(por_rst_n));

  assert_keep_refr_R4: assert property (@(posedge clk) disable iff (!por_rst_n)
    (!sys_rst_n && $past(!sys_rst_n)) |-> ($stable(refr_q) && $stable(rtcdat_q) && $stable(rtcmat_q)));

  assert_sys_vals_R5: assert property (@(posedge clk) disable iff (!por_n)
    !sys_rst_n |-> (ctrl_q == '0 && fbbase_q == FB_RESET));

  assert_stby_run_R6: assert property (@(posedge clk) disable iff (!por_n)
    !run |-> !stby_rst_n);

  assert_cpu_hold_R7: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst_n || !stby_rst_n) |-> !cpu_rst_n);

  assert_cpu_release_R7: assert property (@(posedge clk) disable iff (!por_n)
    $rose(cpu_rst_n) |-> $past(sys_rst_n && stby_rst_n));
endmodule

bind sysreset_hub sysrst_chk u_chk (
  .clk(clk), .por_n(por_n), .pwrfail_n(pwrfail_n), .usr_rst_n(usr_rst_n),
  .run(run), .sys_raw_n(sys_raw_n), .sys_rst_n(sys_rst_n),
  .por_rst_n(por_rst_n), .stby_rst_n(stby_rst_n), .cpu_rst_n(cpu_rst_n),
  .ctrl_q(ctrl_q), .refr_q(refr_q), .rtcdat_q(rtcdat_q),
  .rtcmat_q(rtcmat_q), .fbbase_q(fbbase_q));

// File: tb/sim_sysreset_hub.sv
module sim_sysreset_hub;
  logic clk = 1'b0;
  logic por_n, pwrfail_n, usr_rst_n, run, wr_en;
  logic [2:0] wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic sys_rst_n, por_rst_n, stby_rst_n, cpu_rst_n;
  int checks = 0;
  int errors = 0;
  logic [31:0] shadow [5];

  always #5 clk = ~clk;

  sysreset_hub u0 (.*);

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [31:0] exp);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] pat(input int m, input int a);
    return 32'h1000_0000 * (m + 1) + 32'h0101 * (a + 3) + m;
  endfunction

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    por_n = 0; pwrfail_n = 1; usr_rst_n = 1; run = 1;
    wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    tick(3);
    // reset state
    chk("R1 sys low", {31'b0, sys_rst_n}, 0);
    chk("R3 por low", {31'b0, por_rst_n}, 0);
    chk("R6 stby low", {31'b0, stby_rst_n}, 0);
    chk("R7 cpu low", {31'b0, cpu_rst_n}, 0);
    rd("R5 fb reset", 3'd4, 32'hC000_0000);
    rd("R5 ctrl reset", 3'd0, 0);
    rd("R4 refr reset", 3'd1, 0);
    // release timing
    por_n = 1;
    tick();
    chk("R2 sys edge1", {31'b0, sys_rst_n}, 0);
    chk("R3 por edge1", {31'b0, por_rst_n}, 0);
    tick();
    chk("R2 sys edge2", {31'b0, sys_rst_n}, 1);
    chk("R3 por edge2", {31'b0, por_rst_n}, 1);
    chk("R6 stby edge2", {31'b0, stby_rst_n}, 1);
    chk("R7 cpu edge2", {31'b0, cpu_rst_n}, 0);
    tick();
    chk("R7 cpu edge3", {31'b0, cpu_rst_n}, 1);

    // write map and readback; unmapped addresses
    for (int a = 0; a < 5; a++) begin
      shadow[a] = 32'hA5A5_0000 + a;
      wr(a[2:0], shadow[a]);
    end
    for (int a = 5; a < 8; a++) wr(a[2:0], 32'hDEAD_BEEF);
    for (int a = 0; a < 5; a++) rd("R8 readback", a[2:0], shadow[a]);
    for (int a = 5; a < 8; a++) rd("R8 unmapped zero", a[2:0], 0);

    // standby: run low
    run = 0;
    #1;
    chk("R6 stby async", {31'b0, stby_rst_n}, 0);
    chk("R7 cpu via stby", {31'b0, cpu_rst_n}, 0);
    chk("R6 sys untouched", {31'b0, sys_rst_n}, 1);
    tick(2);
    rd("R6 ctrl kept", 3'd0, shadow[0]);
    run = 1;
    tick();
    chk("R6 stby edge1", {31'b0, stby_rst_n}, 0);
    tick();
    chk("R6 stby edge2", {31'b0, stby_rst_n}, 1);
    chk("R7 cpu stby edge2", {31'b0, cpu_rst_n}, 0);
    tick();
    chk("R7 cpu stby edge3", {31'b0, cpu_rst_n}, 1);

    // sweep every combination of reset sources
    for (int m = 1; m < 8; m++) begin
      for (int a = 0; a < 5; a++) begin
        shadow[a] = pat(m, a);
        wr(a[2:0], shadow[a]);
      end
      // coincident write with reset assertion (R9)
      wr_en = 1; wr_addr = 3'd1; wr_data = 32'hFFFF_0000;
      por_n = !m[0]; pwrfail_n = !m[1]; usr_rst_n = !m[2];
      #1;
      chk("R1 sys async", {31'b0, sys_rst_n}, 0);
      chk("R3 por follows por_n only", {31'b0, por_rst_n}, {31'b0, !m[0]});
      tick();
      wr_en = 0;
      tick();
      por_n = 1; pwrfail_n = 1; usr_rst_n = 1;
      // write during synchroniser release (R9)
      wr_en = 1; wr_addr = 3'd2; wr_data = 32'h5555_AAAA;
      tick();
      wr_en = 0;
      tick(2);
      chk("R7 cpu after sweep", {31'b0, cpu_rst_n}, 1);
      rd("R5 ctrl cleared", 3'd0, 0);
      rd("R5 fb reset value", 3'd4, 32'hC000_0000);
      rd("R4 R9 refr", 3'd1, m[0] ? 32'h0 : shadow[1]);
      rd("R4 R9 rtc data", 3'd2, m[0] ? 32'h0 : shadow[2]);
      rd("R4 rtc match", 3'd3, m[0] ? 32'h0 : shadow[3]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule